// File: doc/BRIEF.md
# Serial Line Auto-Baud Measurement Unit

This unit measures the bit period of a serial receive line by timing a known sync character, 0x55, and writes the result into a baud divisor register. Software arms it with a single request pulse. From then until the measurement ends, the normal receiver is told to stay idle. The unit times the span from the falling edge that opens the start bit to the falling edge that opens data bit 7. That span is exactly eight bit periods. The unit counts a prescaled measurement clock across the span, loads the count into the divisor, drops its armed state and raises a one-cycle completion event.

The arm request can also ask the unit to wait for a line break first, as a LIN-style header requires. In that mode the unit ignores ordinary characters. It only moves on after the line has stayed low for a minimum number of clock cycles and then returned high. The character that follows is the one measured. If the count would pass the top of the divisor range, the counter saturates, an error flag is raised and the old divisor is kept.

Top module: `ab_top`

## Requirements
- R1: After reset, divisor equals DIV_RESET (0), and armed, waitingBreak, rxHold, abDone and abErr are all 0.
- R2: A one-cycle armReq with breakFirst=0, given while the unit is not armed, raises armed. The next falling edge on rxIn starts the measurement.
- R3: The value loaded into divisor is floor(8*T/PRESCALE), where T is the bit period in clock cycles. The span runs from the 1st falling edge to the 5th falling edge of a 0x55 frame (sent LSB first after a low start bit). The 2nd, 3rd and 4th falling edges do not stop the count.
- R4: At completion, armed drops to 0 and abDone is high for exactly one cycle, in the same cycle that divisor takes its new value.
- R5: An armReq with breakFirst=1 raises both armed and waitingBreak. While waitingBreak is high, a low period shorter than BREAK_MIN cycles followed by a rise is ignored: divisor keeps its value and armed stays high.
- R6: A low period of at least BREAK_MIN cycles followed by a rise clears waitingBreak while armed stays high. The next 0x55 character is then measured as in R3.
- R7: If the count would exceed 2^DIV_W-1, abErr is set to 1 and divisor keeps its previous value. armed still clears and abDone still pulses.
- R8: An armReq that arrives while armed is high is ignored. It does not re-enter the break wait and does not disturb the measurement in progress.
- R9: abErr holds until the next accepted armReq, which clears it to 0.
- R10: rxHold is high exactly while armed is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Receive line, idle high |
| armReq | input | 1 | Pulse that arms a measurement |
| breakFirst | input | 1 | Sampled with armReq: wait for a break before measuring |
| divisor | output | DIV_W | Baud divisor register |
| armed | output | 1 | Measurement requested and not yet finished |
| waitingBreak | output | 1 | Waiting for a qualifying break |
| rxHold | output | 1 | Holds the normal receiver idle |
| abDone | output | 1 | One-cycle completion event |
| abErr | output | 1 | Last measurement overflowed |

## Verification
The bench sweeps several bit periods, including odd ones, so that a design that stopped on the wrong falling edge would load a divisor off by a multiple of two bit periods, and an off-by-one prescaler would load a count short by one. In break mode it first sends an ordinary sync character. A design that ignored the break qualifier would measure that character and change the divisor too early. An overlong character drives the counter past its range: a design that wrapped instead of saturating would load a small wrong divisor and leave abErr low. A second arm request during a measurement checks that the unit does not restart, and a later arm checks that the error flag clears.

// File: rtl/ab_pkg.sv
package ab_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BREAK = 2'd1,
    ST_SYNC  = 2'd2,
    ST_MEAS  = 2'd3
  } abState_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic cntClear;
    logic cntRun;
    logic divLoad;
  } abStrobes_t;
endpackage

// File: rtl/ab_datapath.sv
module ab_datapath
  import ab_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int PRESCALE  = 8,
  parameter int BREAK_MIN = 160,
  parameter logic [DIV_W-1:0] DIV_RESET = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  abStrobes_t       strb,
  output logic             fallEdge,
  output logic             riseEdge,
  output logic             longLow,
  output logic             measOvf,
  output logic [DIV_W-1:0] divisor
);
  localparam int LOW_W = $clog2(BREAK_MIN + 1);
  localparam logic [DIV_W-1:0] CNT_MAX = '1;
  localparam logic [LOW_W-1:0] LOW_LIMIT = LOW_W'(BREAK_MIN);

  logic syncA, syncB, lineLast;
  logic [LOW_W-1:0] lowCnt;
  logic [DIV_W-1:0] count, nextCount;
  logic ovfReg, tick, atMax;

  // Two-stage synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      lineLast <= 1'b1;
    end else begin
      syncA    <= rxIn;
      syncB    <= syncA;
      lineLast <= syncB;
    end
  end

  assign fallEdge = lineLast & ~syncB;
  assign riseEdge = ~lineLast & syncB;

  // Low-period length, saturating at the break threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lowCnt <= '0;
    else if (syncB)       lowCnt <= '0;
    else if (!longLow)    lowCnt <= lowCnt + 1'b1;
  end

  assign longLow = (lowCnt >= LOW_LIMIT);

  // Measurement clock prescaler
  generate
    if (PRESCALE == 1) begin : g_noPre
      assign tick = 1'b1;
    end else begin : g_pre
      localparam int PRE_W = $clog2(PRESCALE);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             pre <= '0;
        else if (strb.cntClear) pre <= '0;
        else if (strb.cntRun)  pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
      end
      assign tick = (pre == PRE_LAST);
    end
  endgenerate

  assign atMax     = (count == CNT_MAX);
  assign nextCount = (strb.cntRun && tick && !atMax) ? count + 1'b1 : count;
  assign measOvf   = ovfReg | (strb.cntRun & tick & atMax);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      ovfReg <= 1'b0;
    end else if (strb.cntClear) begin
      count  <= '0;
      ovfReg <= 1'b0;
    end else begin
      count  <= nextCount;
      ovfReg <= measOvf;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          divisor <= DIV_RESET;
    else if (strb.divLoad && !measOvf)  divisor <= nextCount;
  end
endmodule

// File: rtl/ab_control.sv
module ab_control
  import ab_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armReq,
  input  logic       breakFirst,
  input  logic       fallEdge,
  input  logic       riseEdge,
  input  logic       longLow,
  input  logic       measOvf,
  output abStrobes_t strb,
  output logic       armed,
  output logic       waitingBreak,
  output logic       abDone,
  output logic       abErr
);
  abState_t state, stateNxt;
  logic [1:0] skipCnt;
  logic finish;

  // The 5th falling edge ends the span: 1 start edge, 3 skipped, 1 final
  assign finish = (state == ST_MEAS) && fallEdge && (skipCnt == 2'd3);

  always_comb begin
    stateNxt      = state;
    strb.cntClear = 1'b0;
    strb.cntRun   = (state == ST_MEAS);
    strb.divLoad  = finish;
    unique case (state)
      ST_IDLE:  if (armReq) stateNxt = breakFirst ? ST_BREAK : ST_SYNC;
      ST_BREAK: if (riseEdge && longLow) stateNxt = ST_SYNC;
      ST_SYNC:  if (fallEdge) begin
                  stateNxt      = ST_MEAS;
                  strb.cntClear = 1'b1;
                end
      ST_MEAS:  if (finish) stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      skipCnt <= '0;
      abDone  <= 1'b0;
      abErr   <= 1'b0;
    end else begin
      state  <= stateNxt;
      abDone <= finish;
      if (state == ST_SYNC)                skipCnt <= '0;
      else if (state == ST_MEAS && fallEdge) skipCnt <= skipCnt + 1'b1;
      if (state == ST_IDLE && armReq)      abErr <= 1'b0;
      else if (finish)                     abErr <= measOvf;
    end
  end

  assign armed        = (state != ST_IDLE);
  assign waitingBreak = (state == ST_BREAK);
endmodule

// File: rtl/ab_top.sv
module ab_top
  import ab_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int PRESCALE  = 8,
  parameter int BREAK_MIN = 160,
  parameter logic [DIV_W-1:0] DIV_RESET = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  logic             armReq,
  input  logic             breakFirst,
  output logic [DIV_W-1:0] divisor,
  output logic             armed,
  output logic             waitingBreak,
  output logic             rxHold,
  output logic             abDone,
  output logic             abErr
);
  abStrobes_t strb;
  logic fallEdge, riseEdge, longLow, measOvf;

  ab_control u_ctrl (
    .clk(clk), .rstN(rstN), .armReq(armReq), .breakFirst(breakFirst),
    .fallEdge(fallEdge), .riseEdge(riseEdge), .longLow(longLow),
    .measOvf(measOvf), .strb(strb), .armed(armed),
    .waitingBreak(waitingBreak), .abDone(abDone), .abErr(abErr)
  );

  ab_datapath #(
    .DIV_W(DIV_W), .PRESCALE(PRESCALE), .BREAK_MIN(BREAK_MIN), .DIV_RESET(DIV_RESET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .strb(strb),
    .fallEdge(fallEdge), .riseEdge(riseEdge), .longLow(longLow),
    .measOvf(measOvf), .divisor(divisor)
  );

  assign rxHold = armed;
endmodule

// File: rtl/ab_checker.sv
module ab_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             armReq,
  input logic [DIV_W-1:0] divisor,
  input logic             armed,
  input logic             waitingBreak,
  input logic             abDone,
  input logic             abErr
);
  p_done_clears_arm_r4: assert property (@(posedge clk) disable iff (!rstN)
    abDone |-> !armed);

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    abDone |=> !abDone);

  p_div_moves_on_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divisor) |-> abDone);

  p_err_keeps_div_r7: assert property (@(posedge clk) disable iff (!rstN)
    (abDone && abErr) |-> $stable(divisor));

  p_arm_needs_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(armReq));

  p_break_implies_arm_r5: assert property (@(posedge clk) disable iff (!rstN)
    waitingBreak |-> armed);

  p_rearm_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waitingBreak) |-> $past(!armed));
endmodule

bind ab_top ab_checker #(.DIV_W(DIV_W)) u_abChk (
  .clk(clk), .rstN(rstN), .armReq(armReq), .divisor(divisor), .armed(armed),
  .waitingBreak(waitingBreak), .abDone(abDone), .abErr(abErr)
);

// File: tb/tb_ab_top.sv
`timescale 1ns/1ps
module tb_ab_top;
  localparam int DIV_W = 16;
  localparam int PRE   = 2;
  localparam int BRK   = 64;
  localparam int NVEC  = 5;
  // {bit period in clocks, expected divisor = 8*T/PRE}
  localparam int unsigned VEC [NVEC][2] = '{
    '{5, 20}, '{7, 28}, '{12, 48}, '{33, 132}, '{100, 400}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic armReq = 1'b0;
  logic breakFirst = 1'b0;
  logic [DIV_W-1:0] divisor;
  logic armed, waitingBreak, rxHold, abDone, abErr;

  int errors = 0;
  int checks = 0;
  int doneSeen = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ab_top #(.DIV_W(DIV_W), .PRESCALE(PRE), .BREAK_MIN(BRK)) dut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .armReq(armReq), .breakFirst(breakFirst),
    .divisor(divisor), .armed(armed), .waitingBreak(waitingBreak),
    .rxHold(rxHold), .abDone(abDone), .abErr(abErr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (abDone) doneSeen <= doneSeen + 1;
  end

  always @(posedge clk) begin
    if (cycles > 195000 && !finished) begin
      finished = 1'b1;
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic arm(input logic brk);
    @(negedge clk);
    armReq = 1'b1;
    breakFirst = brk;
    @(negedge clk);
    armReq = 1'b0;
    breakFirst = 1'b0;
  endtask

  // 0x55 sent LSB first; short stop period keeps long frames affordable
  task automatic sendSync(input int t);
    logic [7:0] d = 8'h55;
    rxIn = 1'b0;
    idle(t);
    for (int b = 0; b < 8; b++) begin
      rxIn = d[b];
      idle(t);
    end
    rxIn = 1'b1;
    idle(20);
  endtask

  initial begin
    int d0;
    logic [DIV_W-1:0] keep;
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 divisor", divisor, 0);
    chk("R1 armed", armed, 0);
    chk("R1 flags", {waitingBreak, rxHold, abDone, abErr}, 0);

    // R2/R3/R4/R10: table sweep
    for (int v = 0; v < NVEC; v++) begin
      arm(1'b0);
      chk("R2 armed", armed, 1);
      chk("R10 rxHold", rxHold, 1);
      d0 = doneSeen;
      sendSync(int'(VEC[v][0]));
      chk("R3 divisor", divisor, VEC[v][1]);
      chk("R4 armed cleared", armed, 0);
      chk("R4 one done pulse", doneSeen - d0, 1);
      chk("R10 rxHold low", rxHold, 0);
    end

    // R5: break wait ignores an ordinary character
    arm(1'b1);
    chk("R5 waitingBreak", waitingBreak, 1);
    d0 = doneSeen;
    sendSync(10);
    chk("R5 divisor unchanged", divisor, 400);
    chk("R5 still armed", {armed, waitingBreak}, 2'b11);
    chk("R5 no done", doneSeen - d0, 0);
    // R6: qualifying break
    rxIn = 1'b0;
    idle(BRK + 16);
    rxIn = 1'b1;
    idle(12);
    chk("R6 break seen", {armed, waitingBreak}, 2'b10);
    // R8: re-arm while armed is ignored
    arm(1'b1);
    chk("R8 no re-entry to break wait", waitingBreak, 0);
    sendSync(9);
    chk("R6 measured after break", divisor, 36);
    chk("R6 done", doneSeen - d0, 1);

    // R8 during measurement
    arm(1'b0);
    d0 = doneSeen;
    rxIn = 1'b0;
    idle(11);
    arm(1'b1);
    chk("R8 waitingBreak stays low", waitingBreak, 0);
    for (int b = 0; b < 8; b++) begin
      rxIn = b[0] ? 1'b0 : 1'b1;
      idle((b == 0) ? 11 - 2 : 11);
    end
    rxIn = 1'b1;
    idle(20);
    chk("R8 measurement intact", divisor, 44);
    chk("R8 single done", doneSeen - d0, 1);

    // R7: overflow saturates, error set, divisor kept
    keep = divisor;
    arm(1'b0);
    d0 = doneSeen;
    sendSync(16400);
    chk("R7 abErr", abErr, 1);
    chk("R7 divisor kept", divisor, keep);
    chk("R7 armed cleared", armed, 0);
    chk("R7 done pulses", doneSeen - d0, 1);

    // R9: new arm clears error
    arm(1'b0);
    chk("R9 abErr cleared", abErr, 0);
    sendSync(6);
    chk("R9 next divisor", divisor, 24);
    chk("R9 abErr stays low", abErr, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule